// File: doc/BRIEF.md
# MII Receive Frame Event Checker

This block sits beside the receive side of a 4-bit media-independent interface and watches the nibble stream (data valid, receive error, carrier sense and the data nibble) one nibble clock at a time. For every received frame it produces a one-cycle completion pulse with a set of per-frame classification flags. These flags cover receive errors, a dribble or short frame, the range and consistency of the length field, the CRC result supplied from outside, a valid control frame, a clean frame, and a discard decision. CRC computation, buffering and any data path are outside the block.

Alongside the per-frame flags it keeps a small bank of sticky event flags. They gather abnormal line events between two status reads: an overlong carrier, a too-short inter-frame gap, a malformed preamble or start nibble, a false carrier, and a collision while receiving in half duplex. A frame during which any of the frame-level events occurs is marked for discard. Software-facing logic reads the sticky bank and pulses a read strobe to clear it.

Top module: `mii_rx_event_check`

## Requirements
- R1: `frm_done` is high for exactly one cycle, in the cycle after the first idle cycle (the first sampled cycle with `rx_dv` low following `rx_dv` high). The `frm_*` flags change only at that point and hold their values until the next frame completes.
- R2: `frm_rx_err` is 1 exactly when `rx_er` was high in at least one cycle in which `rx_dv` was high during the frame.
- R3: Nibbles after the first 4'hD nibble of a frame are data nibbles, and byte k is built from data nibble 2k (low half) and data nibble 2k+1 (high half). `frm_dribble` is 1 when the data nibble count is zero or odd.
- R4: When `crs` stays high for more than CARRIER_MAX (6072) consecutive cycles, `sticky_ev[0]` is set. A carrier of exactly 6072 cycles sets nothing. If the excess falls inside a frame, that frame has `frm_discard` set.
- R5: When a frame starts after fewer than GAP_MIN (20) idle cycles since the previous frame, `sticky_ev[1]` is set and the frame has `frm_discard` set. With 20 or more idle cycles, and for the first frame after reset, neither is set.
- R6: While `pre_chk_en` is 1, any nibble before the 4'hD start nibble that is not 4'h5 sets `sticky_ev[2]` and marks the frame for discard. While `pre_chk_en` is 0, such a nibble has no effect.
- R7: A cycle with `rx_dv` low, `rx_er` high and `rxd` = 4'hE sets `sticky_ev[3]` and produces no frame completion.
- R8: `tx_start` in a cycle where `half_dup` and `rx_dv` are both high sets `sticky_ev[4]` and marks the frame for discard. With `half_dup` low it has no effect.
- R9: The length field is bytes 12 and 13, with byte 12 as the upper half. A value above MAX_LEN (1500) sets `frm_len_oor` and leaves `frm_len_err` clear. For frames with fewer than 14 bytes, both flags are clear.
- R10: `frm_len_err` is 1 only when all of the following hold: `len_chk_en` is 1, the length field is at most 1500, there is neither a CRC error nor a receive error, and bytes minus 18 differs from the length field. For length values below 46, the expected payload is 46 bytes.
- R11: `crc_err` is sampled in the first idle cycle and reported on `frm_crc_err`. `frm_ok` is 1 only when there is no CRC error, no receive error, no dribble, no discard and no length error.
- R12: `frm_ctrl` is 1 when the length field equals 16'h8808 and the frame would have `frm_ok` set.
- R13: A `status_rd` pulse clears `sticky_ev` at the next edge. An event arriving in the same cycle as the read remains set. Without a read, set bits stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| crs | input | 1 | Carrier sense |
| rxd | input | 4 | Receive data nibble |
| crc_err | input | 1 | External CRC verdict, sampled in first idle cycle |
| tx_start | input | 1 | Local transmit start pulse |
| half_dup | input | 1 | Half-duplex mode |
| pre_chk_en | input | 1 | Enable preamble and start nibble check |
| len_chk_en | input | 1 | Enable length consistency check |
| status_rd | input | 1 | Sticky flag read/clear strobe |
| frm_done | output | 1 | One-cycle frame completion pulse |
| frm_rx_err | output | 1 | Receive error seen in frame |
| frm_dribble | output | 1 | Zero or odd data nibble count |
| frm_len_oor | output | 1 | Length field above 1500 |
| frm_len_err | output | 1 | Length field inconsistent with byte count |
| frm_crc_err | output | 1 | CRC error reported for the frame |
| frm_ctrl | output | 1 | Clean control frame |
| frm_ok | output | 1 | Clean frame |
| frm_discard | output | 1 | Frame must be dropped |
| sticky_ev | output | 5 | Sticky events: 0 long carrier, 1 short gap, 2 bad preamble, 3 false carrier, 4 collision |

## Verification
A wrong nibble phase or byte index shows up at the ports as wrong length flags and a wrong dribble flag on the very next `frm_done`. A drifting carrier or gap counter moves the edge at which `sticky_ev[0]` or `sticky_ev[1]` rises, so the bench probes both counters at the exact boundary values, one cycle either side. A stuck per-frame accumulator leaks an error or discard into the following clean frame, which the randomized frame sequence exposes within one frame. A wrong sticky update is visible at the read immediately after the stimulus.

// File: rtl/mrx_pkg.sv
// Shared constants and types for the MII receive frame event checker.
// Assumes nibble-wide receive data; event indices fix sticky_ev bit positions.
package mrx_pkg;
    localparam int EV_LONG  = 0;
    localparam int EV_GAP   = 1;
    localparam int EV_PRE   = 2;
    localparam int EV_FCAR  = 3;
    localparam int EV_COLL  = 4;
    localparam int NUM_EV   = 5;

    localparam logic [3:0]  NIB_PRE   = 4'h5;
    localparam logic [3:0]  NIB_SFD   = 4'hD;
    localparam logic [3:0]  NIB_FCAR  = 4'hE;
    localparam logic [15:0] CTRL_TYPE = 16'h8808;

    typedef struct packed {
        logic rx_err;
        logic dribble;
        logic len_oor;
        logic len_err;
        logic crc_err;
        logic ctrl;
        logic ok;
        logic discard;
    } frm_stat_t;
endpackage

// File: rtl/mrx_timers.sv
// Carrier-length and inter-frame-gap counters.
// Assumes one nibble per clock; both counters saturate so they never wrap.
// long_ev pulses once, in the (CARRIER_MAX+1)-th consecutive carrier cycle.
// gap_short is meaningful in the cycle a frame starts.
module mrx_timers #(
    parameter int CARRIER_MAX = 6072,
    parameter int GAP_MIN     = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic crs,
    input  logic rx_dv,
    output logic long_ev,
    output logic gap_short
);
    localparam int CW = $clog2(CARRIER_MAX + 2);
    localparam int GW = $clog2(GAP_MIN + 1);
    localparam logic [CW-1:0] CAR_LIM = CW'(CARRIER_MAX);
    localparam logic [CW-1:0] CAR_SAT = CW'(CARRIER_MAX + 1);
    localparam logic [GW-1:0] GAP_LIM = GW'(GAP_MIN);

    logic [CW-1:0] car_cnt;
    logic [GW-1:0] gap_cnt;

    // Count consecutive carrier cycles, saturating one past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            car_cnt <= '0;
        else if (!crs)
            car_cnt <= '0;
        else if (car_cnt != CAR_SAT)
            car_cnt <= car_cnt + 1'b1;
    end

    // Count idle cycles since the last valid nibble; starts saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_cnt <= GAP_LIM;
        else if (rx_dv)
            gap_cnt <= '0;
        else if (gap_cnt != GAP_LIM)
            gap_cnt <= gap_cnt + 1'b1;
    end

    assign long_ev   = crs && (car_cnt == CAR_LIM);
    assign gap_short = (gap_cnt < GAP_LIM);
endmodule

// File: rtl/mrx_nibble_track.sv
// Tracks the preamble/data phase of a frame, counts data nibbles and
// captures the two length-field bytes. Assumes low nibble of each byte
// arrives first and that the first 4'hD nibble ends the preamble.
module mrx_nibble_track #(
    parameter int NIB_W    = 14,
    parameter int LEN_BYTE = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_dv,
    input  logic [3:0]       rxd,
    input  logic             frm_start,
    output logic             pre_bad_nib,
    output logic [NIB_W-1:0] nib_cnt,
    output logic [15:0]      len_field
);
    import mrx_pkg::*;

    localparam logic [NIB_W-1:0] NIB_SAT = '1;
    localparam logic [NIB_W-2:0] IDX_HI  = (NIB_W-1)'(LEN_BYTE);
    localparam logic [NIB_W-2:0] IDX_LO  = (NIB_W-1)'(LEN_BYTE + 1);

    logic             in_data;
    logic [3:0]       lo_nib;
    logic [NIB_W-2:0] byte_idx;
    logic             take_data;

    assign take_data = rx_dv && in_data;
    assign byte_idx  = nib_cnt[NIB_W-1:1];

    // Leave the preamble phase on the start nibble; drop back when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_data <= 1'b0;
        else if (!rx_dv)
            in_data <= 1'b0;
        else if (!in_data && rxd == NIB_SFD)
            in_data <= 1'b1;
    end

    // Count data nibbles of the current frame, held after it ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nib_cnt <= '0;
        else if (frm_start)
            nib_cnt <= '0;
        else if (take_data && nib_cnt != NIB_SAT)
            nib_cnt <= nib_cnt + 1'b1;
    end

    // Assemble bytes and keep the two that form the length field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_nib    <= '0;
            len_field <= '0;
        end else if (frm_start) begin
            len_field <= '0;
        end else if (take_data) begin
            if (!nib_cnt[0])
                lo_nib <= rxd;
            else if (byte_idx == IDX_HI)
                len_field[15:8] <= {rxd, lo_nib};
            else if (byte_idx == IDX_LO)
                len_field[7:0] <= {rxd, lo_nib};
        end
    end

    assign pre_bad_nib = rx_dv && !in_data && (rxd != NIB_PRE) && (rxd != NIB_SFD);
endmodule

// File: rtl/mrx_frame_eval.sv
// Combinational end-of-frame classifier. Assumes its inputs are stable in
// the first idle cycle after a frame, when the top registers the result.
module mrx_frame_eval #(
    parameter int NIB_W     = 14,
    parameter int MAX_LEN   = 1500,
    parameter int MIN_PAY   = 46,
    parameter int HDR_BYTES = 14,
    parameter int OVH_BYTES = 18
) (
    input  logic                  [NIB_W-1:0] nib_cnt,
    input  logic                  [15:0]      len_field,
    input  logic                              crc_err,
    input  logic                              rxe_acc,
    input  logic                              disc_acc,
    input  logic                              len_chk_en,
    output mrx_pkg::frm_stat_t                stat
);
    import mrx_pkg::*;

    localparam logic [31:0] HDR_B = 32'(HDR_BYTES);
    localparam logic [31:0] OVH_B = 32'(OVH_BYTES);
    localparam logic [31:0] LEN_B = 32'(MAX_LEN);
    localparam logic [31:0] PAY_B = 32'(MIN_PAY);

    logic [31:0] nb;
    logic [31:0] lenv;
    logic        lv;
    logic        mism;

    // Derive every per-frame flag from the counts and accumulated events.
    always_comb begin
        nb   = 32'(nib_cnt[NIB_W-1:1]);
        lenv = 32'(len_field);
        lv   = (nb >= HDR_B);
        if (nb < OVH_B)
            mism = 1'b1;
        else if (lenv >= PAY_B)
            mism = ((nb - OVH_B) != lenv);
        else
            mism = ((nb - OVH_B) != PAY_B);

        stat.rx_err  = rxe_acc;
        stat.crc_err = crc_err;
        stat.discard = disc_acc;
        stat.dribble = (nib_cnt == '0) || nib_cnt[0];
        stat.len_oor = lv && (lenv > LEN_B);
        stat.len_err = len_chk_en && lv && (lenv <= LEN_B) && !crc_err && !rxe_acc && mism;
        stat.ok      = !crc_err && !rxe_acc && !stat.dribble && !disc_acc && !stat.len_err;
        stat.ctrl    = lv && (len_field == CTRL_TYPE) && !crc_err && !rxe_acc
                       && !stat.dribble && !disc_acc;
    end
endmodule

// File: rtl/mrx_sticky.sv
// Bank of sticky event flags. A clear strobe empties the bank at the next
// edge, but an event in the same cycle survives the clear.
module mrx_sticky #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] ev,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold one event flag until a read that carries no new event.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else
                q[i] <= (q[i] && !clr) || ev[i];
        end
    end
endmodule

// File: rtl/mii_rx_event_check.sv
// Top of the MII receive frame event checker. Detects frame boundaries,
// gathers line events into sticky flags and per-frame accumulators, and
// registers the frame status one cycle after the first idle cycle.
// Assumes crs, rx_dv, rx_er and rxd are synchronous to clk.
module mii_rx_event_check #(
    parameter int CARRIER_MAX = 6072,
    parameter int GAP_MIN     = 20,
    parameter int NIB_W       = 14,
    parameter int MAX_LEN     = 1500,
    parameter int MIN_PAY     = 46
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_dv,
    input  logic       rx_er,
    input  logic       crs,
    input  logic [3:0] rxd,
    input  logic       crc_err,
    input  logic       tx_start,
    input  logic       half_dup,
    input  logic       pre_chk_en,
    input  logic       len_chk_en,
    input  logic       status_rd,
    output logic       frm_done,
    output logic       frm_rx_err,
    output logic       frm_dribble,
    output logic       frm_len_oor,
    output logic       frm_len_err,
    output logic       frm_crc_err,
    output logic       frm_ctrl,
    output logic       frm_ok,
    output logic       frm_discard,
    output logic [4:0] sticky_ev
);
    import mrx_pkg::*;

    logic             dv_q;
    logic             frm_start;
    logic             frm_end;
    logic             long_ev;
    logic             gap_short;
    logic             pre_bad_nib;
    logic [NIB_W-1:0] nib_cnt;
    logic [15:0]      len_field;
    logic [NUM_EV-1:0] ev;
    logic             frame_ev;
    logic             rxe_acc;
    logic             disc_acc;
    frm_stat_t        stat_d;
    frm_stat_t        stat_q;
    logic             done_q;

    assign frm_start = rx_dv && !dv_q;
    assign frm_end   = !rx_dv && dv_q;

    // Remember last cycle's data-valid for boundary detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dv_q <= 1'b0;
        else        dv_q <= rx_dv;
    end

    mrx_timers #(
        .CARRIER_MAX(CARRIER_MAX),
        .GAP_MIN    (GAP_MIN)
    ) u_timers (
        .clk      (clk),
        .rst_n    (rst_n),
        .crs      (crs),
        .rx_dv    (rx_dv),
        .long_ev  (long_ev),
        .gap_short(gap_short)
    );

    mrx_nibble_track #(
        .NIB_W   (NIB_W),
        .LEN_BYTE(12)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_dv      (rx_dv),
        .rxd        (rxd),
        .frm_start  (frm_start),
        .pre_bad_nib(pre_bad_nib),
        .nib_cnt    (nib_cnt),
        .len_field  (len_field)
    );

    // Raw event strobes for this cycle, one per sticky bit.
    always_comb begin
        ev           = '0;
        ev[EV_LONG]  = long_ev;
        ev[EV_GAP]   = frm_start && gap_short;
        ev[EV_PRE]   = pre_chk_en && pre_bad_nib;
        ev[EV_FCAR]  = !rx_dv && rx_er && (rxd == NIB_FCAR);
        ev[EV_COLL]  = tx_start && half_dup && rx_dv;
        frame_ev     = (ev[EV_LONG] && rx_dv) || ev[EV_GAP] || ev[EV_PRE] || ev[EV_COLL];
    end

    // Accumulate receive errors and discard causes across one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxe_acc  <= 1'b0;
            disc_acc <= 1'b0;
        end else if (frm_start) begin
            rxe_acc  <= rx_er;
            disc_acc <= frame_ev;
        end else if (rx_dv) begin
            rxe_acc  <= rxe_acc || rx_er;
            disc_acc <= disc_acc || frame_ev;
        end
    end

    mrx_frame_eval #(
        .NIB_W    (NIB_W),
        .MAX_LEN  (MAX_LEN),
        .MIN_PAY  (MIN_PAY),
        .HDR_BYTES(14),
        .OVH_BYTES(18)
    ) u_eval (
        .nib_cnt   (nib_cnt),
        .len_field (len_field),
        .crc_err   (crc_err),
        .rxe_acc   (rxe_acc),
        .disc_acc  (disc_acc),
        .len_chk_en(len_chk_en),
        .stat      (stat_d)
    );

    // Register the frame verdict in the first idle cycle; pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= frm_end;
            if (frm_end) stat_q <= stat_d;
        end
    end

    mrx_sticky #(.N(NUM_EV)) u_sticky (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (status_rd),
        .ev   (ev),
        .q    (sticky_ev)
    );

    assign frm_done    = done_q;
    assign frm_rx_err  = stat_q.rx_err;
    assign frm_dribble = stat_q.dribble;
    assign frm_len_oor = stat_q.len_oor;
    assign frm_len_err = stat_q.len_err;
    assign frm_crc_err = stat_q.crc_err;
    assign frm_ctrl    = stat_q.ctrl;
    assign frm_ok      = stat_q.ok;
    assign frm_discard = stat_q.discard;
endmodule

// File: rtl/mrx_event_check.sv
// Assertion checker for mii_rx_event_check, attached with bind below.
module mrx_event_check (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_dv,
    input logic       rx_er,
    input logic [3:0] rxd,
    input logic       tx_start,
    input logic       half_dup,
    input logic       status_rd,
    input logic       frm_done,
    input logic       frm_rx_err,
    input logic       frm_dribble,
    input logic       frm_len_oor,
    input logic       frm_len_err,
    input logic       frm_crc_err,
    input logic       frm_ctrl,
    input logic       frm_ok,
    input logic       frm_discard,
    input logic [4:0] sticky_ev
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> !frm_done); // R1
    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> (!$past(rx_dv) && $past(rx_dv, 2))); // R1
    AST_FCAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_dv && rx_er && rxd == 4'hE) |=> sticky_ev[3]); // R7
    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && half_dup && rx_dv) |=> sticky_ev[4]); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rd |=> ((sticky_ev & $past(sticky_ev)) == $past(sticky_ev))); // R13
    AST_LEN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> !(frm_len_oor && frm_len_err)); // R9
    AST_LENERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_len_err) |-> (!frm_crc_err && !frm_rx_err)); // R10
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_ok) |-> !(frm_crc_err || frm_rx_err || frm_dribble
                                   || frm_discard || frm_len_err)); // R11
    AST_CTRL_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_ctrl) |-> (frm_ok && frm_len_oor)); // R12
endmodule

bind mii_rx_event_check mrx_event_check u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_dv      (rx_dv),
    .rx_er      (rx_er),
    .rxd        (rxd),
    .tx_start   (tx_start),
    .half_dup   (half_dup),
    .status_rd  (status_rd),
    .frm_done   (frm_done),
    .frm_rx_err (frm_rx_err),
    .frm_dribble(frm_dribble),
    .frm_len_oor(frm_len_oor),
    .frm_len_err(frm_len_err),
    .frm_crc_err(frm_crc_err),
    .frm_ctrl   (frm_ctrl),
    .frm_ok     (frm_ok),
    .frm_discard(frm_discard),
    .sticky_ev  (sticky_ev)
);

// File: tb/mii_rx_event_check_test.sv
module mii_rx_event_check_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_dv, rx_er, crs, crc_err, tx_start, half_dup;
    logic       pre_chk_en, len_chk_en, status_rd;
    logic [3:0] rxd;
    logic       frm_done, frm_rx_err, frm_dribble, frm_len_oor, frm_len_err;
    logic       frm_crc_err, frm_ctrl, frm_ok, frm_discard;
    logic [4:0] sticky_ev;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] fb [0:3199];

    always #5 clk = ~clk;

    mii_rx_event_check uut (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs),
        .rxd(rxd), .crc_err(crc_err), .tx_start(tx_start), .half_dup(half_dup),
        .pre_chk_en(pre_chk_en), .len_chk_en(len_chk_en), .status_rd(status_rd),
        .frm_done(frm_done), .frm_rx_err(frm_rx_err), .frm_dribble(frm_dribble),
        .frm_len_oor(frm_len_oor), .frm_len_err(frm_len_err),
        .frm_crc_err(frm_crc_err), .frm_ctrl(frm_ctrl), .frm_ok(frm_ok),
        .frm_discard(frm_discard), .sticky_ev(sticky_ev)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Read and clear the sticky bank; leaves one idle cycle behind.
    task automatic read_clear(input logic [4:0] exp);
        chk("R13 sticky value", 32'(sticky_ev), 32'(exp));
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        chk("R13 sticky cleared", 32'(sticky_ev), 0);
    endtask

    function automatic bit mism_f(input int nbytes, input int lenv);
        if (nbytes < 18) return 1'b1;
        if (lenv >= 46) return (nbytes - 18) != lenv;
        return (nbytes - 18) != 46;
    endfunction

    // Send one frame from fb[], then check status and sticky bits.
    task automatic send_frame(input int nbytes, input bit odd, input int er_pos,
                              input bit crc, input bit pre_bad, input bit coll,
                              input bit exp_gap);
        int nn = 2 * nbytes + (odd ? 1 : 0);
        bit e_rxe, e_drib, e_long, e_pre, e_coll, e_disc, lv, e_oor, e_lerr, e_ok, e_ctrl;
        int lenv;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            rx_dv = 1'b1; crs = 1'b1;
            rxd = (pre_bad && i == 2) ? 4'h7 : 4'h5;
        end
        @(negedge clk);
        rxd = 4'hD;
        for (int i = 0; i < nn; i++) begin
            @(negedge clk);
            if (i < 2 * nbytes) rxd = (i % 2 == 1) ? fb[i/2][7:4] : fb[i/2][3:0];
            else                rxd = 4'h3;
            rx_er    = (i == er_pos);
            tx_start = (coll && i == 3);
        end
        @(negedge clk);
        rx_dv = 1'b0; crs = 1'b0; rx_er = 1'b0; tx_start = 1'b0; rxd = 4'h0;
        crc_err = crc;
        chk("R1 no done before end", 32'(frm_done), 0);
        @(negedge clk);
        crc_err = 1'b0;

        e_rxe  = (er_pos >= 0) && (er_pos < nn);
        e_drib = (nn == 0) || odd;
        e_long = (16 + nn) > 6072;
        e_pre  = pre_bad && pre_chk_en;
        e_coll = coll && half_dup && (nn > 3);
        e_disc = e_pre || e_coll || exp_gap || e_long;
        lv     = nbytes >= 14;
        lenv   = lv ? int'({fb[12], fb[13]}) : 0;
        e_oor  = lv && lenv > 1500;
        e_lerr = len_chk_en && lv && lenv <= 1500 && !crc && !e_rxe && mism_f(nbytes, lenv);
        e_ok   = !crc && !e_rxe && !e_drib && !e_disc && !e_lerr;
        e_ctrl = lv && lenv == 32'h8808 && e_ok;

        chk("R1 done pulse",      32'(frm_done),    1);
        chk("R2 rx_err",          32'(frm_rx_err),  32'(e_rxe));
        chk("R3 dribble",         32'(frm_dribble), 32'(e_drib));
        chk("R9 len_oor",         32'(frm_len_oor), 32'(e_oor));
        chk("R10 len_err",        32'(frm_len_err), 32'(e_lerr));
        chk("R11 crc_err",        32'(frm_crc_err), 32'(crc));
        chk("R11 ok",             32'(frm_ok),      32'(e_ok));
        chk("R12 ctrl",           32'(frm_ctrl),    32'(e_ctrl));
        chk("R4 R5 R6 R8 discard",32'(frm_discard), 32'(e_disc));
        read_clear({e_coll, 1'b0, e_pre, exp_gap, e_long});
        chk("R1 done one cycle",  32'(frm_done),    0);
    endtask

    // Hold carrier alone for n cycles; check the long-carrier bit.
    task automatic carrier_only(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            crs = 1'b1;
        end
        @(negedge clk);
        crs = 1'b0;
        chk("R4 carrier limit", 32'(sticky_ev[0]), 32'(n > 6072));
        chk("R4 no frame", 32'(frm_done), 0);
        read_clear({4'b0, n > 6072});
    endtask

    task automatic fill(input int nbytes, input logic [15:0] lenf);
        for (int i = 0; i < nbytes; i++) fb[i] = 8'($urandom);
        fb[12] = lenf[15:8];
        fb[13] = lenf[7:0];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R1 actual hung expected finish");
        summary();
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; rx_dv = 0; rx_er = 0; crs = 0; rxd = 0; crc_err = 0;
        tx_start = 0; half_dup = 0; pre_chk_en = 0; len_chk_en = 0; status_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset done", 32'(frm_done), 0);
        chk("R11 reset ok", 32'(frm_ok), 0);
        chk("R13 reset sticky", 32'(sticky_ev), 0);

        // First frame after reset: no gap event (R5), matched length (R10).
        len_chk_en = 1;
        fill(70, 16'd52);
        send_frame(70, 0, -1, 0, 0, 0, 0);
        repeat (17) @(negedge clk);
        // Preamble and start nibble only: dribble (R3).
        send_frame(0, 0, -1, 0, 0, 0, 0);
        repeat (17) @(negedge clk);
        // Short frame: length flags clear (R9).
        fill(10, 16'h0000);
        send_frame(10, 0, -1, 0, 0, 0, 0);
        repeat (17) @(negedge clk);
        // Length 1501 with check enabled: out of range only (R9).
        fill(64, 16'd1501);
        send_frame(64, 0, -1, 0, 0, 0, 0);
        repeat (17) @(negedge clk);
        // Mismatch with check disabled: no length error (R10).
        len_chk_en = 0;
        fill(64, 16'd200);
        send_frame(64, 0, -1, 0, 0, 0, 0);
        repeat (17) @(negedge clk);
        // Mismatch with check enabled (R10), then small length padded to 46.
        len_chk_en = 1;
        send_frame(64, 0, -1, 0, 0, 0, 0);
        repeat (17) @(negedge clk);
        fill(64, 16'd20);
        send_frame(64, 0, -1, 0, 0, 0, 0);
        // Gap of 19 idle cycles: short (R5); 20: not short.
        repeat (16) @(negedge clk);
        send_frame(64, 0, -1, 0, 0, 0, 1);
        repeat (17) @(negedge clk);
        send_frame(64, 0, -1, 0, 0, 0, 0);
        repeat (17) @(negedge clk);
        // Control frame (R12), bad preamble ignored then flagged (R6).
        fill(64, 16'h8808);
        send_frame(64, 0, -1, 0, 1, 0, 0);
        repeat (17) @(negedge clk);
        pre_chk_en = 1;
        send_frame(64, 0, -1, 0, 1, 0, 0);
        repeat (17) @(negedge clk);
        // Collision in full duplex ignored, in half duplex flagged (R8).
        send_frame(64, 0, -1, 0, 0, 1, 0);
        repeat (17) @(negedge clk);
        half_dup = 1;
        send_frame(64, 0, -1, 0, 0, 1, 0);
        repeat (17) @(negedge clk);
        half_dup = 0;
        // False carrier, then read in the same cycle as a new event (R7, R13).
        @(negedge clk);
        rx_er = 1; rxd = 4'hE; crs = 1;
        @(negedge clk);
        rx_er = 0; rxd = 0; crs = 0;
        chk("R7 false carrier sticky", 32'(sticky_ev), 32'h08);
        chk("R7 no frame", 32'(frm_done), 0);
        status_rd = 1; rx_er = 1; rxd = 4'hE; crs = 1;
        @(negedge clk);
        rx_er = 0; rxd = 0; crs = 0;
        chk("R13 same-cycle event kept", 32'(sticky_ev), 32'h08);
        @(negedge clk);
        status_rd = 0;
        chk("R13 cleared after read", 32'(sticky_ev), 0);
        repeat (4) @(negedge clk);
        chk("R13 stays clear", 32'(sticky_ev), 0);
        // Carrier boundary (R4).
        carrier_only(6072);
        repeat (25) @(negedge clk);
        carrier_only(6073);
        repeat (25) @(negedge clk);
        // Long frame discarded (R4).
        fill(3100, 16'h0600);
        send_frame(3100, 0, -1, 0, 0, 0, 0);
        repeat (21) @(negedge clk);

        // Constrained random frames.
        for (int f = 0; f < 40; f++) begin
            int mode = int'($urandom_range(0, 4));
            int nb;
            logic [15:0] lf;
            case (mode)
                0: begin nb = int'($urandom_range(64, 120)); lf = 16'(nb - 18); end
                1: begin nb = int'($urandom_range(14, 120)); lf = 16'($urandom_range(0, 1500)); end
                2: begin nb = int'($urandom_range(14, 120)); lf = 16'($urandom_range(1501, 16'hFFFF)); end
                3: begin nb = int'($urandom_range(60, 90));  lf = 16'h8808; end
                default: begin nb = 64; lf = 16'($urandom_range(0, 45)); end
            endcase
            fill(nb, lf);
            pre_chk_en = 1'($urandom);
            len_chk_en = 1'($urandom);
            half_dup   = 1'($urandom);
            send_frame(nb, ($urandom_range(0, 5) == 0),
                       ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 2 * nb - 1)) : -1,
                       ($urandom_range(0, 5) == 0), ($urandom_range(0, 7) == 0),
                       ($urandom_range(0, 7) == 0), 0);
            repeat (21) @(negedge clk);
        end
        summary();
    end
endmodule